// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that software must service on a regular basis. A down-counter runs while the run bit is set. When the counter first reaches zero, the block raises a timeout flag and reloads the counter from a programmable reload value. The timeout flag drives the interrupt line while running is enabled. If the counter reaches zero again before software has cleared the flag, and the reset-enable bit is set, the block raises a reset request that stays high until the block itself is reset. Software clears the flag through a clear register, and the clear also restarts a full period.

Writes to the configuration are guarded by a key. Writing any value other than the key closes access. Writing the key opens it again. A test register holds a stall bit. While that bit is set and the debug-halt input is high, the counter freezes, so a debugger can stop the processor without the watchdog firing.

All registers are reached through a simple synchronous bus. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the counter and the reload value are all ones, the counter is stopped, the lock reads 0 (open), CTRL reads 0, and `irq` and `rst_req` are low.
- R2: CTRL (word address 2) holds the run bit in bit 0 and the reset-enable bit in bit 1, and it reads back as written. While the run bit is 1, the counter decrements once per clock. The first decrement happens on the edge after the edge that wrote the bit. While the run bit is 0, the counter holds its value.
- R3: When the running counter is at zero on a clock edge, the timeout flag becomes 1 and the counter takes the reload value.
- R4: When the running counter is at zero on an edge where the flag is already 1 and reset-enable is 1, `rst_req` goes high and stays high until reset. With reset-enable 0, `rst_req` stays low.
- R5: An accepted write to LOAD (word address 0) updates the reload value. If the run bit is 1, the same edge also copies the written value into the counter. If the run bit is 0, the counter does not change.
- R6: An accepted write of zero to LOAD sets the timeout flag on that edge, whether or not the counter runs.
- R7: A write to KEY (word address 6) of any value other than 32'h1ACCE551 closes access, and KEY then reads 1. A write of 32'h1ACCE551 opens access, and KEY then reads 0.
- R8: While access is closed, writes to CTRL and LOAD change nothing.
- R9: RAW (word address 3) bit 0 shows the timeout flag. MASKED (word address 4) bit 0 and the `irq` output show the flag ANDed with the run bit.
- R10: A write to CLEAR (word address 5) with bit 0 set clears the flag and reloads the counter from the reload value. A write with bit 0 clear has no effect.
- R11: TEST (word address 7) bit 0 is the stall bit. While it is 1 and `dbg_halt` is high, the counter holds. While it is 0, the counter runs regardless of `dbg_halt`.
- R12: If an expiry and a flag-clearing write fall on the same edge, the expiry wins and the flag stays 1. The reset decision uses the flag value from before that edge.
- R13: COUNT (word address 1) reads the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| dbg_halt | input | 1 | Processor halted by debugger |
| irq | output | 1 | Timeout interrupt (masked flag) |
| rst_req | output | 1 | Sticky reset request after second timeout |

## Verification
Two functions can fall on the same edge: the counter's expiry and the software write that clears the flag. The bench provokes this by counting the cycles down to zero exactly, then issuing the clear write on the edge where the counter stands at zero. It does this twice: once with the flag already pending and reset-enable set, and once with no flag pending. In both runs the flag must read 1 afterwards and the counter must hold the reload value. The reset request must be high only in the pending-flag run.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;

    // Word addresses on the register bus
    localparam int unsigned REG_LOAD   = 0;
    localparam int unsigned REG_COUNT  = 1;
    localparam int unsigned REG_CTRL   = 2;
    localparam int unsigned REG_RAW    = 3;
    localparam int unsigned REG_MASKED = 4;
    localparam int unsigned REG_CLEAR  = 5;
    localparam int unsigned REG_KEY    = 6;
    localparam int unsigned REG_TEST   = 7;

    // Field positions
    localparam int unsigned CTRL_RUN_BIT   = 0;
    localparam int unsigned CTRL_RSTEN_BIT = 1;
    localparam int unsigned CLEAR_BIT      = 0;
    localparam int unsigned STALL_BIT      = 0;

    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import twostage_wdog_pkg::*;
#(
    parameter int unsigned      CNT_W      = 32,
    parameter int unsigned      ADDR_W     = 4,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output ctrl_t             ctrl,
    output logic              stall_en,
    output logic              locked,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_strobe,
    output logic              clear_strobe
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             locked;
        logic             stall;
        logic [CNT_W-1:0] load;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic hit_load, hit_ctrl, hit_clear, hit_key, hit_test;

    always_comb begin
        hit_load  = bus_we && (bus_addr == ADDR_W'(REG_LOAD));
        hit_ctrl  = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
        hit_clear = bus_we && (bus_addr == ADDR_W'(REG_CLEAR));
        hit_key   = bus_we && (bus_addr == ADDR_W'(REG_KEY));
        hit_test  = bus_we && (bus_addr == ADDR_W'(REG_TEST));

        st_d = st_q;
        if (hit_ctrl && !st_q.locked) begin
            st_d.ctrl.run    = bus_wdata[CTRL_RUN_BIT];
            st_d.ctrl.rst_en = bus_wdata[CTRL_RSTEN_BIT];
        end
        if (hit_load && !st_q.locked) begin
            st_d.load = bus_wdata;
        end
        if (hit_key) begin
            st_d.locked = (bus_wdata != UNLOCK_KEY);
        end
        if (hit_test) begin
            st_d.stall = bus_wdata[STALL_BIT];
        end

        load_strobe  = hit_load && !st_q.locked;
        clear_strobe = hit_clear && bus_wdata[CLEAR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '0, locked: 1'b0, stall: 1'b0, load: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign stall_en = st_q.stall;
    assign locked   = st_q.locked;
    assign load_val = st_q.load;

    // R8: closed access freezes the guarded configuration
    p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> ($stable(st_q.ctrl) && $stable(st_q.load)));

    // R7: a non-key write to the key register closes access
    p_lock_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_KEY) && bus_wdata != UNLOCK_KEY) |=> st_q.locked);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import twostage_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             stall_en,
    input  logic             dbg_halt,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_strobe,
    input  logic [CNT_W-1:0] load_data,
    input  logic             clear_strobe,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             rst_req;
    } core_state_t;

    core_state_t st_d, st_q;

    logic frozen, tick, expire;

    always_comb begin
        frozen = stall_en && dbg_halt;
        tick   = ctrl.run && !frozen;
        expire = tick && (st_q.cnt == '0);

        st_d = st_q;

        if (tick) begin
            st_d.cnt = expire ? load_val : st_q.cnt - 1'b1;
        end

        if (clear_strobe) begin
            st_d.flag = 1'b0;
            st_d.cnt  = load_val;
        end

        // expiry outranks a clear on the same edge; the reset decision
        // looks at the flag as it stood before this edge
        if (expire) begin
            st_d.flag = 1'b1;
            if (st_q.flag && ctrl.rst_en) begin
                st_d.rst_req = 1'b1;
            end
        end

        if (load_strobe) begin
            if (ctrl.run) begin
                st_d.cnt = load_data;
            end
            if (load_data == '0) begin
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '1, flag: 1'b0, rst_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign flag    = st_q.flag;
    assign rst_req = st_q.rst_req;

    // R4: the reset request never drops before reset
    p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> st_q.rst_req);

    // R4: the request only rises with a pending flag and reset enabled
    p_rst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rst_req) |-> $past(st_q.flag && ctrl.rst_en));

    // R3: expiry reloads from the reload value
    p_expiry_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && !(stall_en && dbg_halt) && st_q.cnt == '0 && !load_strobe)
        |=> (st_q.cnt == $past(load_val) && st_q.flag));

    // R6: a zero reload raises the flag
    p_zero_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && load_data == '0) |=> st_q.flag);

    // R11: stall plus halt freezes the counter
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && dbg_halt && !load_strobe && !clear_strobe) |=> $stable(st_q.cnt));

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int unsigned      CNT_W      = 32,
    parameter int unsigned      ADDR_W     = 4,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              rst_req
);

    ctrl_t            ctrl;
    logic             stall_en;
    logic             locked;
    logic [CNT_W-1:0] load_val;
    logic             load_strobe;
    logic             clear_strobe;
    logic [CNT_W-1:0] count;
    logic             flag;

    wdog_cfg #(
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .ctrl         (ctrl),
        .stall_en     (stall_en),
        .locked       (locked),
        .load_val     (load_val),
        .load_strobe  (load_strobe),
        .clear_strobe (clear_strobe)
    );

    wdog_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .stall_en     (stall_en),
        .dbg_halt     (dbg_halt),
        .load_val     (load_val),
        .load_strobe  (load_strobe),
        .load_data    (bus_wdata),
        .clear_strobe (clear_strobe),
        .count        (count),
        .flag         (flag),
        .rst_req      (rst_req)
    );

    assign irq = flag && ctrl.run;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_LOAD):   bus_rdata = load_val;
            ADDR_W'(REG_COUNT):  bus_rdata = count;
            ADDR_W'(REG_CTRL): begin
                bus_rdata[CTRL_RUN_BIT]   = ctrl.run;
                bus_rdata[CTRL_RSTEN_BIT] = ctrl.rst_en;
            end
            ADDR_W'(REG_RAW):    bus_rdata[0] = flag;
            ADDR_W'(REG_MASKED): bus_rdata[0] = irq;
            ADDR_W'(REG_KEY):    bus_rdata[0] = locked;
            ADDR_W'(REG_TEST):   bus_rdata[STALL_BIT] = stall_en;
            default:             bus_rdata = '0;
        endcase
    end

    // R9: the interrupt line never shows a flag that is not raised
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ctrl.run));

endmodule

// File: tb/twostage_wdog_tb_top.sv
module twostage_wdog_tb_top;

    localparam logic [3:0]  A_LOAD = 4'd0, A_COUNT = 4'd1, A_CTRL = 4'd2, A_RAW = 4'd3,
                            A_MASKED = 4'd4, A_CLEAR = 4'd5, A_KEY = 4'd6, A_TEST = 4'd7;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twostage_wdog dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_halt  (dbg_halt),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, $sformatf("reg %0d", a), bus_rdata, exp);
    endtask

    // caller stands at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        chk_reg("R1", A_COUNT, 32'hFFFF_FFFF);
        chk_reg("R1", A_LOAD, 32'hFFFF_FFFF);
        chk_reg("R1", A_KEY, 32'd0);
        chk_reg("R1", A_CTRL, 32'd0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        chk("R1", "rst_req", {31'd0, rst_req}, 32'd0);
        tick(5);
        chk_reg("R2", A_COUNT, 32'hFFFF_FFFF);
    endtask

    task automatic t_run_stop();
        wr(A_CTRL, 32'd1);
        chk_reg("R2", A_CTRL, 32'd1);
        tick(3);
        chk_reg("R13", A_COUNT, 32'hFFFF_FFFC);
        wr(A_CTRL, 32'd0);
        tick(4);
        chk_reg("R2", A_COUNT, 32'hFFFF_FFFB);
    endtask

    task automatic t_load_copy();
        wr(A_LOAD, 32'd10);
        chk_reg("R5", A_COUNT, 32'hFFFF_FFFB);
        chk_reg("R5", A_LOAD, 32'd10);
        wr(A_CTRL, 32'd1);
        wr(A_LOAD, 32'd20);
        chk_reg("R5", A_COUNT, 32'd20);
    endtask

    task automatic t_expiry_clear();
        tick(20);
        chk_reg("R3", A_COUNT, 32'd0);
        chk_reg("R3", A_RAW, 32'd0);
        tick(1);
        chk_reg("R3", A_RAW, 32'd1);
        chk_reg("R3", A_COUNT, 32'd20);
        chk("R9", "irq", {31'd0, irq}, 32'd1);
        tick(21);
        chk("R4", "rst_req without enable", {31'd0, rst_req}, 32'd0);
        chk_reg("R3", A_COUNT, 32'd20);
        wr(A_CLEAR, 32'd2);
        chk_reg("R10", A_RAW, 32'd1);
        chk_reg("R10", A_COUNT, 32'd19);
        wr(A_CLEAR, 32'd1);
        chk_reg("R10", A_RAW, 32'd0);
        chk_reg("R10", A_COUNT, 32'd20);
        chk("R10", "irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_zero_mask();
        wr(A_CTRL, 32'd0);
        chk_reg("R2", A_COUNT, 32'd19);
        wr(A_LOAD, 32'd0);
        chk_reg("R6", A_RAW, 32'd1);
        chk_reg("R6", A_COUNT, 32'd19);
        chk_reg("R9", A_MASKED, 32'd0);
        chk("R9", "irq masked off", {31'd0, irq}, 32'd0);
        wr(A_CTRL, 32'd1);
        chk_reg("R9", A_MASKED, 32'd1);
        chk("R9", "irq", {31'd0, irq}, 32'd1);
        wr(A_LOAD, 32'd50);
        wr(A_CLEAR, 32'd1);
        chk_reg("R10", A_COUNT, 32'd50);
    endtask

    task automatic t_second_stage();
        wr(A_CTRL, 32'd3);
        chk_reg("R2", A_CTRL, 32'd3);
        wr(A_LOAD, 32'd6);
        tick(7);
        chk_reg("R3", A_RAW, 32'd1);
        chk("R4", "rst_req after first", {31'd0, rst_req}, 32'd0);
        tick(6);
        chk("R4", "rst_req before second", {31'd0, rst_req}, 32'd0);
        tick(1);
        chk("R4", "rst_req after second", {31'd0, rst_req}, 32'd1);
        tick(3);
        chk("R4", "rst_req sticky", {31'd0, rst_req}, 32'd1);
        do_reset();
        chk("R4", "rst_req after reset", {31'd0, rst_req}, 32'd0);
    endtask

    task automatic t_lock();
        wr(A_KEY, 32'd5);
        chk_reg("R7", A_KEY, 32'd1);
        wr(A_CTRL, 32'd1);
        chk_reg("R8", A_CTRL, 32'd0);
        tick(2);
        chk_reg("R8", A_COUNT, 32'hFFFF_FFFF);
        wr(A_LOAD, 32'd7);
        chk_reg("R8", A_LOAD, 32'hFFFF_FFFF);
        wr(A_KEY, KEY);
        chk_reg("R7", A_KEY, 32'd0);
        wr(A_CTRL, 32'd1);
        chk_reg("R7", A_CTRL, 32'd1);
    endtask

    task automatic t_stall();
        wr(A_LOAD, 32'd100);
        wr(A_TEST, 32'd1);
        chk_reg("R11", A_COUNT, 32'd99);
        dbg_halt = 1'b1;
        tick(5);
        chk_reg("R11", A_COUNT, 32'd99);
        dbg_halt = 1'b0;
        tick(2);
        chk_reg("R11", A_COUNT, 32'd97);
        wr(A_TEST, 32'd0);
        dbg_halt = 1'b1;
        tick(3);
        chk_reg("R11", A_COUNT, 32'd93);
        dbg_halt = 1'b0;
    endtask

    task automatic t_collide();
        wr(A_CTRL, 32'd3);
        wr(A_LOAD, 32'd4);
        tick(5);
        chk_reg("R3", A_RAW, 32'd1);
        tick(4);
        chk_reg("R12", A_COUNT, 32'd0);
        wr(A_CLEAR, 32'd1);
        chk_reg("R12", A_RAW, 32'd1);
        chk_reg("R12", A_COUNT, 32'd4);
        chk("R12", "rst_req pending", {31'd0, rst_req}, 32'd1);
        do_reset();
        wr(A_CTRL, 32'd3);
        wr(A_LOAD, 32'd3);
        tick(3);
        chk_reg("R12", A_COUNT, 32'd0);
        wr(A_CLEAR, 32'd1);
        chk_reg("R12", A_RAW, 32'd1);
        chk_reg("R12", A_COUNT, 32'd3);
        chk("R12", "rst_req none pending", {31'd0, rst_req}, 32'd0);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_run_stop();
        t_load_copy();
        t_expiry_clear();
        t_zero_mask();
        t_second_stage();
        t_lock();
        t_stall();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule